// File: doc/BRIEF.md
# Per-Class Trace Address Delta Encoder

This block is the front end of a compressor for streams of memory-reference records. Each incoming record carries a reference class (instruction fetch, data read, data write, or one spare class) and an address. The encoder keeps one base register for each class. For every record it takes the difference between the new address and the base of the same class. A small difference goes out as a short delta record. A large one goes out as a full-address record. Keeping a separate base for each class exposes the locality inside each class, which a single shared "previous address" would hide when classes interleave.

Input and output each use a valid/ready handshake with one register stage between them. A matching decoder, `trace_delta_dec`, holds the same per-class bases and rebuilds the original stream. It is used for loopback testing. The delta threshold is a run-time input that is sampled with each accepted record. Differences are taken modulo 2^ADDR_W. The magnitude of the most negative difference is 2^(ADDR_W-1).

Top module: `trace_delta_enc`

## Requirements
- R1: After reset, out_valid_o is 0, in_ready_o is 1, and every class base is zero, so the first record of any class is measured against address 0.
- R2: The difference for a record is taken against the base of that record's own class only. Records of other classes never change it.
- R3: If the magnitude of diff = (in_addr_i - base) mod 2^ADDR_W, read as signed, is strictly less than thresh_i, the output has out_fmt_o = 1 and out_payload_o = diff.
- R4: Otherwise the output has out_fmt_o = 0 and out_payload_o = in_addr_i.
- R5: After every accepted record, in either output form, the base of its class becomes in_addr_i.
- R6: out_label_o equals the label of the record that produced the output.
- R7: While out_valid_o = 1 and out_ready_i = 0, in_ready_o is 0 and all output fields hold steady.
- R8: Every accepted record yields exactly one output record. Records are never dropped or reordered.
- R9: The decoder, fed with the encoder's output, reproduces every label and address exactly and in order.
- R10: A magnitude equal to thresh_i gives a full record, thresh_i = 0 gives only full records, and the most negative difference is handled as magnitude 2^(ADDR_W-1).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| thresh_i | input | ADDR_W | Delta magnitude limit, sampled on accept |
| in_valid_i | input | 1 | Input record valid |
| in_ready_o | output | 1 | Encoder can accept a record |
| in_label_i | input | CLASS_W | Reference class of the input record |
| in_addr_i | input | ADDR_W | Reference address |
| out_valid_o | output | 1 | Output record valid |
| out_ready_i | input | 1 | Downstream accepts the output record |
| out_fmt_o | output | 1 | 1 = delta record, 0 = full-address record |
| out_label_o | output | CLASS_W | Reference class of the output record |
| out_payload_o | output | ADDR_W | Signed delta or full address |

## Verification
The bench targets several boundaries:
- A magnitude exactly at the threshold; a design using less-or-equal would emit a delta there.
- A zero threshold, which must always give full records.
- The wrap to the most negative difference; a design whose absolute value overflows would call it tiny.
- A negative delta reached from the zero reset base.

Interleaved classes expose a design that shares one base across classes. A run of full records followed by a small step catches a base that is refreshed only on delta records. Random back-pressure on both stages catches records lost or duplicated when the input is accepted while the output is stalled. Decoder loopback catches any payload the decoder cannot invert.

// File: rtl/tde_pkg.sv
package tde_pkg;
  localparam logic FMT_FULL  = 1'b0;
  localparam logic FMT_DELTA = 1'b1;

  typedef enum logic [1:0] {
    CLS_IFETCH = 2'd0,
    CLS_DREAD  = 2'd1,
    CLS_DWRITE = 2'd2,
    CLS_SPARE  = 2'd3
  } ref_class_e;
endpackage

// File: rtl/tde_base_regs.sv
module tde_base_regs #(
  parameter int ADDR_W      = 32,
  parameter int NUM_CLASSES = 4,
  localparam int CLASS_W    = $clog2(NUM_CLASSES)
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               wr_en_i,
  input  logic [CLASS_W-1:0] wr_cls_i,
  input  logic [ADDR_W-1:0]  wr_addr_i,
  input  logic [CLASS_W-1:0] rd_cls_i,
  output logic [ADDR_W-1:0]  rd_addr_o
);
  logic [ADDR_W-1:0] base_q [NUM_CLASSES];

  for (genvar c = 0; c < NUM_CLASSES; c++) begin : g_base
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) base_q[c] <= '0;
      else if (wr_en_i && wr_cls_i == CLASS_W'(c)) base_q[c] <= wr_addr_i;
    end
  end

  always_comb begin
    rd_addr_o = '0;
    for (int c = 0; c < NUM_CLASSES; c++)
      if (rd_cls_i == CLASS_W'(c)) rd_addr_o = base_q[c];
  end
endmodule

// File: rtl/tde_delta_sel.sv
module tde_delta_sel #(
  parameter int ADDR_W = 32
) (
  input  logic [ADDR_W-1:0] cur_addr_i,
  input  logic [ADDR_W-1:0] base_addr_i,
  input  logic [ADDR_W-1:0] thresh_i,
  output logic              use_delta_o,
  output logic [ADDR_W-1:0] payload_o
);
  logic [ADDR_W-1:0] diff, mag;

  always_comb begin
    diff        = cur_addr_i - base_addr_i;
    // unsigned view: most negative difference maps to 2^(ADDR_W-1)
    mag         = diff[ADDR_W-1] ? (~diff + 1'b1) : diff;
    use_delta_o = mag < thresh_i;
    payload_o   = use_delta_o ? diff : cur_addr_i;
  end
endmodule

// File: rtl/tde_slice.sv
module tde_slice #(
  parameter int DATA_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              in_valid_i,
  output logic              in_ready_o,
  input  logic [DATA_W-1:0] in_data_i,
  output logic              out_valid_o,
  input  logic              out_ready_i,
  output logic [DATA_W-1:0] out_data_o
);
  logic              valid_q;
  logic [DATA_W-1:0] data_q;

  assign in_ready_o  = !valid_q || out_ready_i;
  assign out_valid_o = valid_q;
  assign out_data_o  = data_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_q <= 1'b0;
      data_q  <= '0;
    end else if (in_ready_o) begin
      valid_q <= in_valid_i;
      if (in_valid_i) data_q <= in_data_i;
    end
  end
endmodule

// File: rtl/trace_delta_dec.sv
module trace_delta_dec #(
  parameter int ADDR_W      = 32,
  parameter int NUM_CLASSES = 4,
  localparam int CLASS_W    = $clog2(NUM_CLASSES)
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               in_valid_i,
  output logic               in_ready_o,
  input  logic               in_fmt_i,
  input  logic [CLASS_W-1:0] in_label_i,
  input  logic [ADDR_W-1:0]  in_payload_i,
  output logic               out_valid_o,
  input  logic               out_ready_i,
  output logic [CLASS_W-1:0] out_label_o,
  output logic [ADDR_W-1:0]  out_addr_o
);
  localparam int REC_W = CLASS_W + ADDR_W;

  logic [ADDR_W-1:0] base, addr;
  logic [REC_W-1:0]  rec_q;
  logic              acc;

  assign acc  = in_valid_i && in_ready_o;
  assign addr = (in_fmt_i == tde_pkg::FMT_DELTA) ? base + in_payload_i : in_payload_i;

  tde_base_regs #(.ADDR_W(ADDR_W), .NUM_CLASSES(NUM_CLASSES)) u_base (
    .clk_i, .rst_ni,
    .wr_en_i(acc), .wr_cls_i(in_label_i), .wr_addr_i(addr),
    .rd_cls_i(in_label_i), .rd_addr_o(base)
  );

  tde_slice #(.DATA_W(REC_W)) u_slice (
    .clk_i, .rst_ni,
    .in_valid_i, .in_ready_o, .in_data_i({in_label_i, addr}),
    .out_valid_o, .out_ready_i, .out_data_o(rec_q)
  );

  assign {out_label_o, out_addr_o} = rec_q;
endmodule

// File: rtl/trace_delta_enc.sv
module trace_delta_enc #(
  parameter int ADDR_W      = 32,
  parameter int NUM_CLASSES = 4,
  localparam int CLASS_W    = $clog2(NUM_CLASSES)
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [ADDR_W-1:0]  thresh_i,
  input  logic               in_valid_i,
  output logic               in_ready_o,
  input  logic [CLASS_W-1:0] in_label_i,
  input  logic [ADDR_W-1:0]  in_addr_i,
  output logic               out_valid_o,
  input  logic               out_ready_i,
  output logic               out_fmt_o,
  output logic [CLASS_W-1:0] out_label_o,
  output logic [ADDR_W-1:0]  out_payload_o
);
  localparam int REC_W = 1 + CLASS_W + ADDR_W;

  logic [ADDR_W-1:0] base, payload;
  logic              use_delta, acc;
  logic [REC_W-1:0]  rec_q;

  assign acc = in_valid_i && in_ready_o;

  tde_base_regs #(.ADDR_W(ADDR_W), .NUM_CLASSES(NUM_CLASSES)) u_base (
    .clk_i, .rst_ni,
    .wr_en_i(acc), .wr_cls_i(in_label_i), .wr_addr_i(in_addr_i),
    .rd_cls_i(in_label_i), .rd_addr_o(base)
  );

  tde_delta_sel #(.ADDR_W(ADDR_W)) u_sel (
    .cur_addr_i(in_addr_i), .base_addr_i(base), .thresh_i,
    .use_delta_o(use_delta), .payload_o(payload)
  );

  tde_slice #(.DATA_W(REC_W)) u_slice (
    .clk_i, .rst_ni,
    .in_valid_i, .in_ready_o,
    .in_data_i({use_delta ? tde_pkg::FMT_DELTA : tde_pkg::FMT_FULL, in_label_i, payload}),
    .out_valid_o, .out_ready_i, .out_data_o(rec_q)
  );

  assign {out_fmt_o, out_label_o, out_payload_o} = rec_q;
endmodule

// File: rtl/trace_delta_enc_chk.sv
module trace_delta_enc_chk #(
  parameter int ADDR_W  = 32,
  parameter int CLASS_W = 2
) (
  input logic               clk_i,
  input logic               rst_ni,
  input logic [ADDR_W-1:0]  thresh_i,
  input logic               in_valid_i,
  input logic               in_ready_o,
  input logic [CLASS_W-1:0] in_label_i,
  input logic [ADDR_W-1:0]  in_addr_i,
  input logic               out_valid_o,
  input logic               out_ready_i,
  input logic               out_fmt_o,
  input logic [CLASS_W-1:0] out_label_o,
  input logic [ADDR_W-1:0]  out_payload_o
);
  function automatic logic [ADDR_W-1:0] mag_of(input logic [ADDR_W-1:0] v);
    return v[ADDR_W-1] ? (~v + 1'b1) : v;
  endfunction

  logic acc;
  assign acc = in_valid_i && in_ready_o;

  AST_STALL_BLOCKS_INPUT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_valid_o && !out_ready_i |-> !in_ready_o); // R7
  AST_STALL_HOLDS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_valid_o && !out_ready_i |=> out_valid_o && $stable(out_fmt_o)
      && $stable(out_label_o) && $stable(out_payload_o)); // R7
  AST_EMPTY_ACCEPTS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !out_valid_o |-> in_ready_o); // R8
  AST_ACCEPT_EMITS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    acc |=> out_valid_o); // R8
  AST_LABEL_KEPT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    acc |=> out_label_o == $past(in_label_i)); // R6
  AST_FULL_IS_ADDR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    acc |=> out_fmt_o || out_payload_o == $past(in_addr_i)); // R4
  AST_DELTA_BELOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    acc |=> !out_fmt_o || mag_of(out_payload_o) < $past(thresh_i)); // R3
  AST_ZERO_THRESH_FULL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    acc && thresh_i == '0 |=> !out_fmt_o); // R10
endmodule

bind trace_delta_enc trace_delta_enc_chk #(.ADDR_W(ADDR_W), .CLASS_W(CLASS_W)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .thresh_i(thresh_i),
  .in_valid_i(in_valid_i), .in_ready_o(in_ready_o),
  .in_label_i(in_label_i), .in_addr_i(in_addr_i),
  .out_valid_o(out_valid_o), .out_ready_i(out_ready_i),
  .out_fmt_o(out_fmt_o), .out_label_o(out_label_o), .out_payload_o(out_payload_o)
);

// File: tb/trace_delta_enc_tb.sv
module trace_delta_enc_tb;
  localparam int CLK_PERIOD = 10;
  localparam int AW = 8;
  localparam int CW = 2;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  logic [AW-1:0] thr = '0;
  logic          in_valid = 1'b0, in_ready;
  logic [CW-1:0] in_label = '0;
  logic [AW-1:0] in_addr = '0;
  logic          e_valid, e_fmt, d_in_ready;
  logic [CW-1:0] e_label;
  logic [AW-1:0] e_pay;
  logic          d_valid, d_ready = 1'b1;
  logic [CW-1:0] d_label;
  logic [AW-1:0] d_addr;

  trace_delta_enc #(.ADDR_W(AW), .NUM_CLASSES(4)) u_dut (
    .clk_i(clk), .rst_ni(rst_n), .thresh_i(thr),
    .in_valid_i(in_valid), .in_ready_o(in_ready),
    .in_label_i(in_label), .in_addr_i(in_addr),
    .out_valid_o(e_valid), .out_ready_i(d_in_ready),
    .out_fmt_o(e_fmt), .out_label_o(e_label), .out_payload_o(e_pay)
  );

  trace_delta_dec #(.ADDR_W(AW), .NUM_CLASSES(4)) u_dec (
    .clk_i(clk), .rst_ni(rst_n),
    .in_valid_i(e_valid), .in_ready_o(d_in_ready),
    .in_fmt_i(e_fmt), .in_label_i(e_label), .in_payload_i(e_pay),
    .out_valid_o(d_valid), .out_ready_i(d_ready),
    .out_label_o(d_label), .out_addr_o(d_addr)
  );

  int checks = 0, errors = 0;
  int sent = 0, enc_n = 0, dec_n = 0;
  bit stall_mode = 1'b0;
  logic [31:0] rng = 32'h1234_5678;
  logic [AW-1:0] model_base [4];
  logic          exp_fmt [64];
  logic [CW-1:0] exp_lbl [64];
  logic [AW-1:0] exp_pay [64];
  logic [AW-1:0] src_addr [64];
  string         exp_tag [64];

  function automatic logic [31:0] next_rng(input logic [31:0] s);
    logic [31:0] x = s;
    x ^= x << 13; x ^= x >> 17; x ^= x << 5;
    return x;
  endfunction

  task automatic chk(input bit ok, input string what, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", what, act, exp);
    end
  endtask

  // one clock: drive at negedge, observe after settling
  task automatic step(input bit drv, input logic [CW-1:0] c, input logic [AW-1:0] a,
                      output bit taken);
    logic [AW-1:0] diff, mag;
    int k;
    @(negedge clk);
    rng = next_rng(rng);
    in_valid = drv; in_label = c; in_addr = a;
    d_ready  = stall_mode ? (rng[3:2] != 2'b00) : 1'b1;
    #1;
    taken = 1'b0;
    if (e_valid && !d_in_ready)
      chk(in_ready == 1'b0, "R7 in_ready during output stall", int'(in_ready), 0);
    if (e_valid && d_in_ready) begin
      k = enc_n % 64;
      chk(enc_n < sent, "R8 extra output record", enc_n, sent);
      chk(e_fmt == exp_fmt[k], {exp_tag[k], " fmt"}, int'(e_fmt), int'(exp_fmt[k]));
      chk(e_pay == exp_pay[k], {exp_tag[k], " payload (per-class base R2, update R5)"},
          int'(e_pay), int'(exp_pay[k]));
      chk(e_label == exp_lbl[k], "R6 label", int'(e_label), int'(exp_lbl[k]));
      enc_n++;
    end
    if (d_valid && d_ready) begin
      k = dec_n % 64;
      chk(d_addr == src_addr[k], "R9 decoded address", int'(d_addr), int'(src_addr[k]));
      chk(d_label == exp_lbl[k], "R9 decoded label", int'(d_label), int'(exp_lbl[k]));
      dec_n++;
    end
    if (drv && in_ready) begin
      k = sent % 64;
      diff = a - model_base[c];
      mag  = diff[AW-1] ? AW'(-diff) : diff;
      exp_lbl[k] = c;
      src_addr[k] = a;
      if (mag < thr) begin
        exp_fmt[k] = 1'b1; exp_pay[k] = diff; exp_tag[k] = "R3";
      end else begin
        exp_fmt[k] = 1'b0; exp_pay[k] = a;
        exp_tag[k] = (thr == '0 || mag == thr) ? "R10" : "R4";
      end
      model_base[c] = a;
      sent++;
      taken = 1'b1;
    end
  endtask

  task automatic send(input logic [CW-1:0] c, input logic [AW-1:0] a);
    bit t;
    do step(1'b1, c, a, t); while (!t);
  endtask

  task automatic drain();
    bit t;
    while (dec_n < sent) step(1'b0, '0, '0, t);
    step(1'b0, '0, '0, t);
    in_valid = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", dec_n, sent);
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [AW-1:0] a;
    logic [CW-1:0] c;
    for (int i = 0; i < 4; i++) model_base[i] = '0;
    repeat (3) @(posedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(e_valid == 1'b0, "R1 out_valid after reset", int'(e_valid), 0);
    chk(in_ready == 1'b1, "R1 in_ready after reset", int'(in_ready), 1);
    chk(d_valid == 1'b0, "R1 decoder idle after reset", int'(d_valid), 0);

    // directed: zero base (R1), class separation (R2), threshold edge (R10), refresh after full (R5)
    thr = 8'd16;
    send(2'd0, 8'd5);    // delta +5 from zero base
    send(2'd1, 8'd200);  // -56, full
    send(2'd2, 8'd250);  // -6 from zero base
    send(2'd0, 8'd20);   // +15 against class 0, not class 1
    send(2'd0, 8'd36);   // +16 == thr -> full
    send(2'd0, 8'd40);   // +4 after full
    send(2'd3, 8'd128);  // most negative from 0 -> full
    drain();
    chk(sent == 7 && enc_n == 7, "R8 directed count", enc_n, 7);

    // all differences 0..255 in one class, two thresholds incl. 128
    stall_mode = 1'b1;
    for (int t = 0; t < 2; t++) begin
      thr = (t == 0) ? 8'd128 : 8'd64;
      a = model_base[3];
      for (int d = 0; d < 256; d++) begin
        a = a + AW'(d);
        send(2'd3, a);
      end
      drain();
    end

    // interleaved classes with mixed small steps and jumps under back-pressure
    for (int t = 0; t < 6; t++) begin
      case (t)
        0: thr = 8'd0;   1: thr = 8'd1;   2: thr = 8'd2;
        3: thr = 8'd64;  4: thr = 8'd128; default: thr = 8'd255;
      endcase
      for (int n = 0; n < 3000; n++) begin
        rng = next_rng(rng);
        c = rng[1:0];
        if (rng[4]) a = model_base[c] + AW'($signed(rng[11:8]) - 4'sd0);
        else        a = rng[23:16];
        send(c, a);
      end
      drain();
    end

    chk(enc_n == sent, "R8 encoder output count", enc_n, sent);
    chk(dec_n == sent, "R9 decoder output count", dec_n, sent);
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule